// File: doc/BRIEF.md
# Rotating Register File

This block is a small, distributed register file meant to sit next to one functional unit of a modulo-scheduled loop datapath. Each read port and each write port carries its own logical register address. The block adds that address to an internal rotation base and keeps only the low bits of the sum. The result selects a physical entry. Because the base moves by one on every loop iteration, a logical register name refers to a fresh physical entry in each iteration. Values produced in one iteration can then still be read under a shifted name in later iterations, without any explicit copy.

The physical depth is the requested register count rounded up to a power of two. Wrap-around is therefore a truncation of the sum and needs no comparator. The loop controller pulses `advance` once per iteration. The functional unit drives the addresses and data. Reads are combinational. Writes, the base update and reset take effect at the clock edge.

Top module: `rot_regfile`

## Requirements
- R1: The physical depth is NUM_REGS rounded up to the next power of two (8 for the default of 6). Every port addresses physical entry (logical address + base) modulo that depth.
- R2: When `advance` is high at a clock edge, the base becomes (base - 1) modulo the depth after that edge. Writes in that same cycle use the base that was in effect before the edge.
- R3: A read returns, in the same cycle, the entry selected through the current base. When a write targets the same physical entry in the same cycle, the read returns the value the entry held before the write.
- R4: When several write ports target the same physical entry in one cycle, the entry takes the data of the highest-numbered enabled port.
- R5: A synchronous active-high reset clears the base to 0 and every entry to 0.
- R6: A logical address at or above NUM_REGS is not rejected and raises no flag. It wraps modulo the physical depth in the same way as any other address.
- R7: A write port whose enable bit is low changes no entry.
- R8: An advance while the base is 0 wraps the base to depth - 1. After that, logical address 0 selects physical entry depth - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| advance | input | 1 | Iteration step; the base moves down by one at the edge |
| wr_en | input | NWR | Per-port write enable, bit p for write port p |
| wr_addr | input | NWR x ADDR_W | Logical write address for each write port |
| wr_data | input | NWR x DATA_W | Write data for each write port |
| rd_addr | input | NRD x ADDR_W | Logical read address for each read port |
| rd_data | output | NRD x DATA_W | Combinational read data for each read port |

## Verification
Directed sequences first write a value under one logical name, then advance. They confirm that the value reappears under the next-higher logical name, which separates a decrementing base from an incrementing one or a frozen one. Addresses above the register count, a long run of advances and both write ports aimed at one entry single out the wrap arithmetic, the wrap of the base past zero and the port priority. Constrained-random cycles mix advances, partial enables and reads of just-written entries. Against the bench's own model they expose off-by-one-cycle base updates and reads that bypass the new value. A reset in the middle of the run shows whether the base and all entries are cleared.

// File: rtl/rrf_pkg.sv
package rrf_pkg;

    // Index width for a requested register count; at least one bit.
    function automatic int idx_bits(input int count);
        return (count <= 2) ? 1 : $clog2(count);
    endfunction

    // Physical depth: register count rounded up to a power of two.
    function automatic int phys_depth(input int count);
        return 1 << idx_bits(count);
    endfunction

    // Width of the sum that carries the logical address plus the base.
    function automatic int sum_bits(input int addr_w, input int idx_w);
        return ((addr_w > idx_w) ? addr_w : idx_w) + 1;
    endfunction

endpackage

// File: rtl/rrf_base.sv
module rrf_base #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [IDX_W-1:0] base
);

    always_ff @(posedge clk) begin
        if (rst)
            base <= '0;
        else if (advance)
            base <= base - 1'b1;
    end

    p_base_step_r2: assert property (@(posedge clk) disable iff (rst)
        advance |=> base == IDX_W'($past(base) - 1'b1));

    p_base_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(base));

    p_base_clear_r5: assert property (@(posedge clk)
        rst |=> base == '0);

endmodule

// File: rtl/rrf_index.sv
module rrf_index #(
    parameter int ADDR_W = 4,
    parameter int IDX_W  = 3,
    parameter int NPORT  = 2
) (
    input  logic [NPORT-1:0][ADDR_W-1:0] logical,
    input  logic [IDX_W-1:0]             base,
    output logic [NPORT-1:0][IDX_W-1:0]  physical
);
    import rrf_pkg::*;

    localparam int SUM_W = sum_bits(ADDR_W, IDX_W);

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        logic [SUM_W-1:0] sum;
        always_comb begin
            sum         = SUM_W'(logical[g]) + SUM_W'(base);
            physical[g] = sum[IDX_W-1:0];
        end
    end

endmodule

// File: rtl/rrf_store.sv
module rrf_store #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3,
    parameter int NWR    = 2,
    parameter int NRD    = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NWR-1:0]              wr_en,
    input  logic [NWR-1:0][IDX_W-1:0]   wr_idx,
    input  logic [NWR-1:0][DATA_W-1:0]  wr_data,
    input  logic [NRD-1:0][IDX_W-1:0]   rd_idx,
    output logic [NRD-1:0][DATA_W-1:0]  rd_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [NWR-1:0][DEPTH-1:0] wsel;

    for (genvar p = 0; p < NWR; p++) begin : g_dec
        always_comb begin
            wsel[p] = '0;
            if (wr_en[p])
                wsel[p][wr_idx[p]] = 1'b1;
        end

        p_dec_onehot_r1: assert property (@(posedge clk) disable iff (rst)
            $onehot0(wsel[p]) && ($countones(wsel[p]) == 32'(wr_en[p])));
    end

    // Ports are visited in ascending order, so a later port overrides.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < DEPTH; e++)
                mem[e] <= '0;
        end else begin
            for (int e = 0; e < DEPTH; e++)
                for (int p = 0; p < NWR; p++)
                    if (wsel[p][e])
                        mem[e] <= wr_data[p];
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_data[r] = mem[rd_idx[r]];
    end

    p_top_port_lands_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en[NWR-1] |=> mem[$past(wr_idx[NWR-1])] == $past(wr_data[NWR-1]));

    p_entry0_clear_r5: assert property (@(posedge clk)
        rst |=> mem[0] == '0);

endmodule

// File: rtl/rot_regfile.sv
module rot_regfile #(
    parameter int NUM_REGS = 6,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 16,
    parameter int NWR      = 2,
    parameter int NRD      = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        advance,
    input  logic [NWR-1:0]              wr_en,
    input  logic [NWR-1:0][ADDR_W-1:0]  wr_addr,
    input  logic [NWR-1:0][DATA_W-1:0]  wr_data,
    input  logic [NRD-1:0][ADDR_W-1:0]  rd_addr,
    output logic [NRD-1:0][DATA_W-1:0]  rd_data
);
    import rrf_pkg::*;

    localparam int IDX_W = idx_bits(NUM_REGS);

    logic [IDX_W-1:0]           base;
    logic [NWR-1:0][IDX_W-1:0]  wr_idx;
    logic [NRD-1:0][IDX_W-1:0]  rd_idx;

    rrf_base #(.IDX_W(IDX_W)) u_base (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .base    (base)
    );

    rrf_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .NPORT(NWR)) u_widx (
        .logical  (wr_addr),
        .base     (base),
        .physical (wr_idx)
    );

    rrf_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .NPORT(NRD)) u_ridx (
        .logical  (rd_addr),
        .base     (base),
        .physical (rd_idx)
    );

    rrf_store #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NWR(NWR), .NRD(NRD)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

endmodule

// File: tb/sim_rot_regfile.sv
`timescale 1ns/1ps
module sim_rot_regfile;

    localparam int DEPTH = 8;   // 6 registers rounded up (R1)

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             advance = 1'b0;
    logic [1:0]       wr_en = '0;
    logic [1:0][3:0]  wr_addr = '0;
    logic [1:0][15:0] wr_data = '0;
    logic [1:0][3:0]  rd_addr = '0;
    logic [1:0][15:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [15:0] model [DEPTH];
    int base = 0;

    always #10 clk = ~clk;   // 50 MHz

    rot_regfile u0 (
        .clk(clk), .rst(rst), .advance(advance), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic int phys(input logic [3:0] la, input int b);
        return (int'(la) + b) % DEPTH;
    endfunction

    task automatic check(input int port, input logic [15:0] got,
                         input logic [15:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s read port %0d: actual %h expected %h", tag, port, got, exp);
        end
    endtask

    // Drive one cycle from the falling edge, check reads, then update the model at the edge.
    task automatic step(input bit adv, input logic [1:0] en,
                        input logic [3:0] wa0, input logic [3:0] wa1,
                        input logic [15:0] wd0, input logic [15:0] wd1,
                        input logic [3:0] ra0, input logic [3:0] ra1,
                        input string tag);
        advance = adv; wr_en = en;
        wr_addr[0] = wa0; wr_addr[1] = wa1;
        wr_data[0] = wd0; wr_data[1] = wd1;
        rd_addr[0] = ra0; rd_addr[1] = ra1;
        #2;
        check(0, rd_data[0], model[phys(ra0, base)], tag);
        check(1, rd_data[1], model[phys(ra1, base)], tag);
        @(posedge clk);
        if (en[0]) model[phys(wa0, base)] = wd0;
        if (en[1]) model[phys(wa1, base)] = wd1;   // port 1 overrides (R4)
        if (adv) base = (base + DEPTH - 1) % DEPTH;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; advance = 1'b0; wr_en = '0;
        @(posedge clk); @(posedge clk);
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        base = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < DEPTH; i++) model[i] = 16'hxxxx;
        @(negedge clk);
        do_reset();

        // R5: all entries read zero after reset, base at zero
        for (int a = 0; a < DEPTH; a += 2)
            step(0, 2'b00, 0, 0, 0, 0, 4'(a), 4'(a + 1), "R5");

        // R1: write through base 0, then read back at the same logical names
        step(0, 2'b11, 4'd3, 4'd5, 16'h1111, 16'h5555, 4'd3, 4'd5, "R3");
        step(0, 2'b00, 0, 0, 0, 0, 4'd3, 4'd5, "R1");

        // R2: advance while writing; the write uses the old base
        step(1, 2'b01, 4'd2, 0, 16'h2222, 0, 4'd2, 4'd3, "R2");
        step(0, 2'b00, 0, 0, 0, 0, 4'd3, 4'd4, "R2");   // old 2 -> new 3, old 3 -> new 4

        // R6: logical addresses beyond the register count wrap
        step(0, 2'b01, 4'd14, 0, 16'h6E6E, 0, 4'd6, 4'd14, "R6");
        step(0, 2'b00, 0, 0, 0, 0, 4'd6, 4'd14, "R6");

        // R4: both ports on one physical entry, port 1 wins
        step(0, 2'b11, 4'd1, 4'd9, 16'hAAAA, 16'hBBBB, 4'd1, 4'd9, "R4");
        step(0, 2'b00, 0, 0, 0, 0, 4'd1, 4'd9, "R4");

        // R7: disabled writes leave entries alone
        step(0, 2'b00, 4'd4, 4'd4, 16'hDEAD, 16'hBEEF, 4'd4, 4'd4, "R7");
        step(0, 2'b00, 0, 0, 0, 0, 4'd4, 4'd3, "R7");

        // R8: wrap the base past zero
        do_reset();
        step(0, 2'b01, 4'd7, 0, 16'h7777, 0, 4'd7, 4'd0, "R8");
        step(1, 2'b00, 0, 0, 0, 0, 4'd0, 4'd7, "R8");
        step(0, 2'b00, 0, 0, 0, 0, 4'd0, 4'd1, "R8");   // logical 0 now hits entry 7
        for (int k = 0; k < DEPTH; k++)
            step(1, 2'b00, 0, 0, 0, 0, 4'd0, 4'd15, "R8");

        // Random mix (R1 R2 R3 R4 R7)
        for (int n = 0; n < 400; n++)
            step(($urandom % 3) == 0, 2'($urandom), 4'($urandom), 4'($urandom),
                 16'($urandom), 16'($urandom), 4'($urandom), 4'($urandom), "R3");

        // R5: reset in mid-run clears base and entries
        do_reset();
        for (int a = 0; a < DEPTH; a += 2)
            step(0, 2'b00, 0, 0, 0, 0, 4'(a), 4'(a + 9), "R5");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule